// File: doc/BRIEF.md
# Exception Priority and Vector Unit

This block sits beside the status register and register banks of a processor core. It watches seven exception request lines: reset, data abort, fast interrupt, IRQ, prefetch abort, software interrupt and undefined instruction. In any cycle with at least one live request, it picks the most urgent one. One clock later it presents the handler vector, the mode the core enters, and the status word that follows entry. In that same cycle it pulses write strobes. These strobes carry the return PC into the link register of the new mode and the pre-entry status word into that mode's saved status register.

The core supplies its current status word, its current PC, and the saved status register of the mode it is in now. A restore request copies that saved value back into the status word in a single step. This is the only part of an exception return that the block handles. The block contains no bank storage of its own. Its strobes, bank-select code and data are wired straight to the register file.

Top module: `exc_vector_unit`

## Requirements
- R1: When several requests are active together, exactly one is taken. From most to least urgent the order is: reset, data abort, fast interrupt, IRQ, prefetch abort, software interrupt, undefined instruction.
- R2: The vector equals VEC_BASE (default 0) plus a per-source offset: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18, fast interrupt 0x1C.
- R3: The mode code on `bank_mode` and in `status_next[4:0]` is supervisor 10011 for reset and software interrupt, abort 10111 for both aborts, IRQ 10010, fast interrupt 10001, and undefined 11011.
- R4: On entry, `status_next` keeps bits 31:8 of the old status. It sets the IRQ mask (bit 7) and clears the alternate-encoding state bit (bit 5). It sets the fast mask (bit 6) for reset and fast interrupt, and otherwise keeps that bit. Bits 4:0 take the new mode.
- R5: An IRQ request is ignored while status bit 7 is 1. A fast interrupt request is ignored while status bit 6 is 1. A masked request never hides a lower-priority request that is not masked.
- R6: An entry drives `lr_wr`, `sav_wr` and `status_wr` high together for one cycle, exactly one clock after the request is sampled. `lr_value` is the sampled PC and `sav_value` is the sampled status word.
- R7: A restore request with no exception taken, made while the current mode is neither user (10000) nor system (11111), drives `status_wr` with `status_next` equal to the sampled saved status. `lr_wr` and `sav_wr` stay low. In user or system mode the request is ignored and no strobe rises.
- R8: If an exception is taken in the same cycle as a restore request, the exception wins and the restore is dropped.
- R9: While synchronous reset is high, and in the first cycle after it, all strobes are low and all data outputs are zero.
- R10: A cycle with no unmasked request and no valid restore leaves every strobe low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rq_reset | input | 1 | Reset exception request |
| rq_undef | input | 1 | Undefined instruction request |
| rq_swi | input | 1 | Software interrupt request |
| rq_pabort | input | 1 | Prefetch abort request |
| rq_dabort | input | 1 | Data abort request |
| rq_irq | input | 1 | Normal interrupt request |
| rq_fast | input | 1 | Fast interrupt request |
| restore_req | input | 1 | Copy the current mode's saved status back into the status word |
| cur_pc | input | DW | Return PC to be saved on entry |
| cur_status | input | DW | Current status word |
| saved_status | input | DW | Saved status register of the current mode |
| vec_addr | output | DW | Handler vector address, valid while lr_wr is high |
| lr_wr | output | 1 | Link register write strobe, which also marks exception entry |
| lr_value | output | DW | Value written to the link register |
| sav_wr | output | 1 | Saved status register write strobe |
| sav_value | output | DW | Value written to the saved status register |
| bank_mode | output | 5 | Mode whose banked registers the strobes address |
| status_wr | output | 1 | Status word write strobe |
| status_next | output | DW | New status word |

## Verification
A wrong priority choice or a wrong lookup entry shows up as a wrong vector or mode on the same strobe that carries the entry. A faulty mask test shows up as a strobe that appears or goes missing. Either one is visible one clock after the request is sampled. A stale capture register would leave `lr_value` or `sav_value` holding an earlier cycle's PC or status on the next entry, so the bench changes both between entries. A strobe that stays high for a second cycle would show up in the idle cycle the bench checks after each pulse.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;
  localparam int NSRC    = 7;
  localparam int SRC_W   = $clog2(NSRC);
  localparam int MODE_W  = 5;
  localparam int BIT_ALT = 5;   // alternate-encoding state bit
  localparam int BIT_FM  = 6;   // fast interrupt mask
  localparam int BIT_IM  = 7;   // IRQ mask

  localparam logic [MODE_W-1:0] MD_USR  = 5'b10000;
  localparam logic [MODE_W-1:0] MD_FAST = 5'b10001;
  localparam logic [MODE_W-1:0] MD_IRQ  = 5'b10010;
  localparam logic [MODE_W-1:0] MD_SVC  = 5'b10011;
  localparam logic [MODE_W-1:0] MD_ABT  = 5'b10111;
  localparam logic [MODE_W-1:0] MD_UND  = 5'b11011;
  localparam logic [MODE_W-1:0] MD_SYS  = 5'b11111;

  // index equals priority rank, 0 most urgent
  typedef enum logic [SRC_W-1:0] {
    S_RESET = 3'd0, S_DABT = 3'd1, S_FAST = 3'd2, S_IRQ = 3'd3,
    S_PABT = 3'd4, S_SWI = 3'd5, S_UNDEF = 3'd6
  } src_e;

  typedef struct packed {
    logic [7:0]        off;
    logic [MODE_W-1:0] mode;
    logic              set_fm;
  } entry_t;

  function automatic entry_t lookup(src_e s);
    entry_t e;
    case (s)
      S_RESET: e = '{off: 8'h00, mode: MD_SVC,  set_fm: 1'b1};
      S_DABT:  e = '{off: 8'h10, mode: MD_ABT,  set_fm: 1'b0};
      S_FAST:  e = '{off: 8'h1C, mode: MD_FAST, set_fm: 1'b1};
      S_IRQ:   e = '{off: 8'h18, mode: MD_IRQ,  set_fm: 1'b0};
      S_PABT:  e = '{off: 8'h0C, mode: MD_ABT,  set_fm: 1'b0};
      S_SWI:   e = '{off: 8'h08, mode: MD_SVC,  set_fm: 1'b0};
      default: e = '{off: 8'h04, mode: MD_UND,  set_fm: 1'b0};
    endcase
    return e;
  endfunction
endpackage

// File: rtl/exc_prio_select.sv
module exc_prio_select #(
  parameter int N = 7,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/exc_entry_build.sv
module exc_entry_build
  import exc_vec_pkg::*;
#(
  parameter int          DW       = 32,
  parameter logic [DW-1:0] VEC_BASE = '0
) (
  input  src_e              src,
  input  logic [DW-1:0]     status_in,
  output logic [DW-1:0]     vec,
  output logic [MODE_W-1:0] mode,
  output logic [DW-1:0]     status_out
);
  entry_t e;
  always_comb begin
    e          = lookup(src);
    vec        = VEC_BASE + DW'(e.off);
    mode       = e.mode;
    status_out = status_in;
    status_out[MODE_W-1:0] = e.mode;
    status_out[BIT_ALT]    = 1'b0;
    status_out[BIT_IM]     = 1'b1;
    status_out[BIT_FM]     = status_in[BIT_FM] | e.set_fm;
  end
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_vec_pkg::*;
#(
  parameter int            DW       = 32,
  parameter logic [DW-1:0] VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rq_reset,
  input  logic              rq_undef,
  input  logic              rq_swi,
  input  logic              rq_pabort,
  input  logic              rq_dabort,
  input  logic              rq_irq,
  input  logic              rq_fast,
  input  logic              restore_req,
  input  logic [DW-1:0]     cur_pc,
  input  logic [DW-1:0]     cur_status,
  input  logic [DW-1:0]     saved_status,
  output logic [DW-1:0]     vec_addr,
  output logic              lr_wr,
  output logic [DW-1:0]     lr_value,
  output logic              sav_wr,
  output logic [DW-1:0]     sav_value,
  output logic [MODE_W-1:0] bank_mode,
  output logic              status_wr,
  output logic [DW-1:0]     status_next
);
  logic [NSRC-1:0]   qual;
  logic              hit;
  logic [SRC_W-1:0]  win;
  logic [DW-1:0]     vec_c;
  logic [MODE_W-1:0] mode_c;
  logic [DW-1:0]     stat_c;
  logic              priv;
  logic              do_restore;

  // request vector in rank order, masks applied before arbitration
  always_comb begin
    qual          = '0;
    qual[S_RESET] = rq_reset;
    qual[S_DABT]  = rq_dabort;
    qual[S_FAST]  = rq_fast & ~cur_status[BIT_FM];
    qual[S_IRQ]   = rq_irq  & ~cur_status[BIT_IM];
    qual[S_PABT]  = rq_pabort;
    qual[S_SWI]   = rq_swi;
    qual[S_UNDEF] = rq_undef;
  end

  exc_prio_select #(.N(NSRC)) u_sel (
    .req (qual),
    .hit (hit),
    .idx (win)
  );

  exc_entry_build #(.DW(DW), .VEC_BASE(VEC_BASE)) u_build (
    .src        (src_e'(win)),
    .status_in  (cur_status),
    .vec        (vec_c),
    .mode       (mode_c),
    .status_out (stat_c)
  );

  assign priv = (cur_status[MODE_W-1:0] != MD_USR) &&
                (cur_status[MODE_W-1:0] != MD_SYS);
  assign do_restore = restore_req && priv && !hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_addr    <= '0;
      lr_wr       <= 1'b0;
      lr_value    <= '0;
      sav_wr      <= 1'b0;
      sav_value   <= '0;
      bank_mode   <= '0;
      status_wr   <= 1'b0;
      status_next <= '0;
    end else begin
      lr_wr     <= hit;
      sav_wr    <= hit;
      status_wr <= hit || do_restore;
      if (hit) begin
        vec_addr    <= vec_c;
        lr_value    <= cur_pc;
        sav_value   <= cur_status;
        bank_mode   <= mode_c;
        status_next <= stat_c;
      end else if (do_restore) begin
        status_next <= saved_status;
        bank_mode   <= cur_status[MODE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/exc_vector_unit_chk.sv
module exc_vector_unit_chk
  import exc_vec_pkg::*;
#(
  parameter int            DW       = 32,
  parameter logic [DW-1:0] VEC_BASE = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              rq_reset,
  input logic              rq_undef,
  input logic              rq_swi,
  input logic              rq_pabort,
  input logic              rq_dabort,
  input logic              rq_irq,
  input logic              rq_fast,
  input logic              restore_req,
  input logic [DW-1:0]     cur_pc,
  input logic [DW-1:0]     cur_status,
  input logic [DW-1:0]     saved_status,
  input logic [DW-1:0]     vec_addr,
  input logic              lr_wr,
  input logic [DW-1:0]     lr_value,
  input logic              sav_wr,
  input logic [DW-1:0]     sav_value,
  input logic [MODE_W-1:0] bank_mode,
  input logic              status_wr,
  input logic [DW-1:0]     status_next
);
  logic any_rq;
  logic others_quiet;
  logic in_priv;
  assign any_rq = rq_reset | rq_undef | rq_swi | rq_pabort |
                  rq_dabort | rq_irq | rq_fast;
  assign others_quiet = !(rq_reset | rq_undef | rq_swi | rq_pabort |
                          rq_dabort | rq_fast);
  assign in_priv = cur_status[4:0] != MD_USR && cur_status[4:0] != MD_SYS;

  assert_reset_wins_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(rq_reset)) |->
      (lr_wr && vec_addr == VEC_BASE && bank_mode == MD_SVC));

  assert_entry_status_R4: assert property (@(posedge clk) disable iff (rst)
    lr_wr |-> (status_wr && status_next[BIT_IM] && !status_next[BIT_ALT] &&
               status_next[4:0] == bank_mode));

  assert_irq_masked_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(rq_irq && cur_status[BIT_IM] && others_quiet &&
                          !restore_req)) |-> !status_wr);

  assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
    lr_wr |-> (sav_wr && lr_value == $past(cur_pc) &&
               sav_value == $past(cur_status)));

  assert_restore_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(restore_req && !any_rq && in_priv)) |->
      (status_wr && !lr_wr && status_next == $past(saved_status)));

  assert_exc_beats_restore_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(restore_req && rq_dabort)) |->
      (lr_wr && bank_mode == MD_ABT));

  assert_no_lone_save_R10: assert property (@(posedge clk) disable iff (rst)
    !lr_wr |-> !sav_wr);
endmodule

bind exc_vector_unit exc_vector_unit_chk #(.DW(DW), .VEC_BASE(VEC_BASE)) u_chk (.*);

// File: tb/sim_exc_vector_unit.sv
module sim_exc_vector_unit;
  localparam int DW = 32;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [6:0] rq = '0;  // rank order: reset,dabt,fast,irq,pabt,swi,undef
  logic restore_req = 1'b0;
  logic [DW-1:0] cur_pc = '0, cur_status = '0, saved_status = '0;
  logic [DW-1:0] vec_addr, lr_value, sav_value, status_next;
  logic lr_wr, sav_wr, status_wr;
  logic [4:0] bank_mode;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_vector_unit #(.DW(DW)) u0 (
    .clk(clk), .rst(rst),
    .rq_reset(rq[0]), .rq_undef(rq[6]), .rq_swi(rq[5]), .rq_pabort(rq[4]),
    .rq_dabort(rq[1]), .rq_irq(rq[3]), .rq_fast(rq[2]),
    .restore_req(restore_req), .cur_pc(cur_pc), .cur_status(cur_status),
    .saved_status(saved_status), .vec_addr(vec_addr), .lr_wr(lr_wr),
    .lr_value(lr_value), .sav_wr(sav_wr), .sav_value(sav_value),
    .bank_mode(bank_mode), .status_wr(status_wr), .status_next(status_next)
  );

  function automatic logic [7:0] exp_off(int r);
    case (r)
      0: return 8'h00; 1: return 8'h10; 2: return 8'h1C; 3: return 8'h18;
      4: return 8'h0C; 5: return 8'h08; default: return 8'h04;
    endcase
  endfunction
  function automatic logic [4:0] exp_mode(int r);
    case (r)
      0, 5: return 5'b10011; 1, 4: return 5'b10111; 2: return 5'b10001;
      3: return 5'b10010; default: return 5'b11011;
    endcase
  endfunction
  function automatic logic [DW-1:0] exp_stat(int r, logic [DW-1:0] s);
    logic [DW-1:0] v;
    v = s;
    v[4:0] = exp_mode(r);
    v[5] = 1'b0;
    v[7] = 1'b1;
    if (r == 0 || r == 2) v[6] = 1'b1;
    return v;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // apply current inputs at one edge, sample just after it
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    rq = '0; restore_req = 1'b0;
    step();
  endtask

  task automatic check_entry(string req, int r, logic [DW-1:0] pc, logic [DW-1:0] st);
    chk(lr_wr && sav_wr && status_wr, req, "strobes", {lr_wr, sav_wr, status_wr}, 3'b111);
    chk(vec_addr == DW'(exp_off(r)), req, "vector", vec_addr, DW'(exp_off(r)));
    chk(bank_mode == exp_mode(r), req, "mode", bank_mode, exp_mode(r));
    chk(status_next == exp_stat(r, st), req, "status", status_next, exp_stat(r, st));
    chk(lr_value == pc, req, "link value", lr_value, pc);
    chk(sav_value == st, req, "saved value", sav_value, st);
  endtask

  task automatic t_reset_state();
    rst = 1'b1;
    step();
    chk(!lr_wr && !sav_wr && !status_wr, "R9", "strobes in reset", {lr_wr, sav_wr, status_wr}, 0);
    chk(vec_addr == 0 && status_next == 0 && lr_value == 0, "R9", "data in reset", vec_addr | status_next | lr_value, 0);
    rst = 1'b0;
    step();
    chk(!lr_wr && !status_wr, "R9", "first cycle after reset", {lr_wr, status_wr}, 0);
  endtask

  task automatic t_single_sources();
    for (int r = 0; r < 7; r++) begin
      cur_pc = 32'h0000_8000 + 32'(r * 16);
      cur_status = 32'h6000_0030 ^ 32'(r << 24); // user mode, bit5 set, masks clear
      rq = 7'(1 << r);
      step();
      check_entry("R2 R3 R4 R6", r, cur_pc, cur_status);
      idle();
      chk(!lr_wr && !sav_wr && !status_wr, "R6", "single-cycle pulse", {lr_wr, sav_wr, status_wr}, 0);
    end
  endtask

  task automatic t_priority();
    for (int hi = 0; hi < 7; hi++) begin
      for (int lo = hi + 1; lo < 7; lo++) begin
        cur_pc = 32'h1000 + 32'(hi * 8 + lo);
        cur_status = 32'h8000_001F;
        rq = 7'((1 << hi) | (1 << lo));
        step();
        chk(vec_addr == DW'(exp_off(hi)) && lr_wr, "R1", "pair winner vector", vec_addr, DW'(exp_off(hi)));
        idle();
      end
    end
    rq = 7'h7F; cur_status = 32'h0000_0010;
    step();
    chk(vec_addr == 0 && bank_mode == 5'b10011, "R1", "all requests", vec_addr, 0);
    idle();
  endtask

  task automatic t_masking();
    cur_status = 32'h0000_0090; rq = 7'b0001000; // IRQ masked by bit7
    step();
    chk(!lr_wr && !status_wr, "R5", "masked IRQ ignored", {lr_wr, status_wr}, 0);
    cur_status = 32'h0000_0050; rq = 7'b0000100; // fast masked by bit6
    step();
    chk(!lr_wr && !status_wr, "R5", "masked fast ignored", {lr_wr, status_wr}, 0);
    cur_status = 32'h0000_0050; rq = 7'b0001000; // bit6 does not mask IRQ
    step();
    chk(lr_wr && vec_addr == 32'h18, "R5", "IRQ with fast mask", vec_addr, 32'h18);
    cur_status = 32'h0000_00D0; rq = 7'b0011100; // both masked, prefetch below
    step();
    chk(lr_wr && vec_addr == 32'h0C, "R5", "masked reqs fall through", vec_addr, 32'h0C);
    chk(status_next[6] == 1'b1, "R4", "fast mask kept", status_next[6], 1);
    cur_status = 32'h0000_00D0; rq = 7'b0000001; // reset unmaskable
    step();
    chk(lr_wr && vec_addr == 0, "R5", "reset ignores masks", vec_addr, 0);
    idle();
  endtask

  task automatic t_restore();
    cur_status = 32'h2000_0092; saved_status = 32'hF000_0030; restore_req = 1'b1;
    step();
    chk(status_wr && !lr_wr && !sav_wr, "R7", "restore strobes", {status_wr, lr_wr, sav_wr}, 3'b100);
    chk(status_next == 32'hF000_0030, "R7", "restore value", status_next, 32'hF000_0030);
    cur_status = 32'h0000_0010; saved_status = 32'h1234_5678;
    step();
    chk(!status_wr, "R7", "restore ignored in user", status_wr, 0);
    cur_status = 32'h0000_001F;
    step();
    chk(!status_wr, "R7", "restore ignored in system", status_wr, 0);
    cur_status = 32'h0000_0013; rq = 7'b0000010; cur_pc = 32'hABCD_0000;
    step();
    check_entry("R8", 1, 32'hABCD_0000, 32'h0000_0013);
    idle();
  endtask

  task automatic t_idle();
    cur_status = 32'h0000_0013; cur_pc = 32'h55;
    idle();
    chk(!lr_wr && !sav_wr && !status_wr, "R10", "no request", {lr_wr, sav_wr, status_wr}, 0);
    rq = 7'b0001000; cur_status = 32'h0000_0093;
    step();
    chk(!lr_wr && !status_wr, "R10", "only masked request", {lr_wr, status_wr}, 0);
    idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: actual running expected finished");
    finish_run();
  end

  initial begin
    #1;
    t_reset_state();
    t_single_sources();
    t_priority();
    t_masking();
    t_restore();
    t_idle();
    finish_run();
  end
endmodule